// File: doc/BRIEF.md
# Triple-Channel Word Majority Voter

This block takes three conversion results that three identical converter channels produced at the same sampling instant, and turns them into one trusted result per sample. The words are compared as whole words. A value that appears on at least two channels is passed on. A single channel that disagrees with the other two is masked and marked as outvoted. When all three words differ, no result can be trusted, so the block outputs a safe word supplied by the system instead.

Voting happens only on cycles where the shared sample strobe is high. The outcome is registered, so results appear one clock after the strobe, together with a one-cycle valid pulse. Between strobes, the voted word and the flags hold their last values.

Each channel has its own saturating count of how many samples outvoted it. A channel that is outvoted again and again can then be told apart from one hit by a single transient. A synchronous clear input sets all three counts back to zero.

The outcome of the latest sample is held in a small state register with four states:
- IDLE: the state after reset.
- UNANIMOUS: all three channels agreed.
- MASKED: exactly one channel was outvoted.
- SAFE: no two channels agreed.

On every strobe the register moves from any state to the state that matches the outcome of that sample. Without a strobe it stays where it is. The no-majority output is high exactly while the register is in SAFE.

Top module: `tmr_word_voter`

## Requirements
- R1: During and right after reset, `vote_word` is zero and `vote_valid`, `outvoted`, `no_majority` and all miss counts are zero.
- R2: `vote_valid` is high for exactly the one cycle that follows a clock edge at which `sample_vld` was high. It is low after any edge at which `sample_vld` was low.
- R3: When all three channel words are equal, the voted word equals that value, `outvoted` is 000 and `no_majority` is 0.
- R4: When exactly two channel words are equal, the voted word is the shared value and `outvoted` has only bit i set, where i is the number of the odd channel (bit 0 is ch0, bit 1 is ch1, bit 2 is ch2).
- R5: When all three channel words differ, the voted word equals `safe_word` as sampled with the strobe, `no_majority` is 1 and `outvoted` is 000.
- R6: Without a strobe, changes on the channel words or on `safe_word` have no effect: `vote_word`, `outvoted` and `no_majority` hold their values.
- R7: Each sample that outvotes channel i adds one to the count of that channel. The count of channel i sits at bits [i*CNT_W +: CNT_W] of `miss_count`.
- R8: A miss count stops at its all-ones value and does not wrap.
- R9: A high `clr_counts` at a clock edge zeroes all three counts at that edge. It takes priority over an increment at the same edge, and it does not affect the vote.
- R10: Samples that are unanimous or that have no majority leave every miss count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously to all state |
| sample_vld | input | 1 | Shared strobe: the three channel words belong to one sampling instant |
| ch0_word | input | DATA_W | Conversion result of channel 0 |
| ch1_word | input | DATA_W | Conversion result of channel 1 |
| ch2_word | input | DATA_W | Conversion result of channel 2 |
| safe_word | input | DATA_W | Value forced out when no two channels agree |
| clr_counts | input | 1 | Synchronous clear of all miss counts |
| vote_word | output | DATA_W | Registered voted result |
| vote_valid | output | 1 | One-cycle pulse marking a new voted result |
| outvoted | output | 3 | Per-channel flag: that channel was the odd one in the latest sample |
| no_majority | output | 1 | Latest sample had no two agreeing channels; the safe word is being output |
| miss_count | output | 3*CNT_W | Three saturating outvote counts, channel 0 in the low field |

## Verification
The bench builds the voter with an 8-bit word and a 3-bit count field. The narrow count tops out at seven, so ten outvotes of one channel drive it through saturation in a few cycles. Such a short run can then also check that the clear wins over an increment at the same edge. The 8-bit words leave room for distinct agreeing, odd and safe values, so the test can tell which source produced the voted output.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

    // Number of redundant converter channels being voted.
    localparam int N_CH = 3;

    // Outcome of the most recent voted sample.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_UNANIMOUS = 2'd1,
        ST_MASKED    = 2'd2,
        ST_SAFE      = 2'd3
    } vote_state_e;

endpackage

// File: rtl/tmr_word_compare.sv
// Combinational whole-word comparison of the three channels.
// Pair p compares channel p with channel (p+1) mod N_CH.
module tmr_word_compare
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [N_CH-1:0][DATA_W-1:0] ch_words,
    input  logic [DATA_W-1:0]           safe_word,
    output logic [DATA_W-1:0]           pick_word,
    output logic [N_CH-1:0]             odd_mask,
    output logic                        all_agree,
    output logic                        none_agree
);

    logic [N_CH-1:0] pair_eq;

    // Exact equality per ring-ordered pair.
    for (genvar p = 0; p < N_CH; p++) begin : g_pair
        assign pair_eq[p] = (ch_words[p] == ch_words[(p + 1) % N_CH]);
    end

    // Channel i is odd when the other two agree and it differs from them.
    // The pair that excludes channel i is pair (i+1).
    for (genvar i = 0; i < N_CH; i++) begin : g_odd
        assign odd_mask[i] = pair_eq[(i + 1) % N_CH] & ~pair_eq[i];
    end

    assign all_agree  = &pair_eq;
    assign none_agree = ~|pair_eq;

    // Channel 0 is part of pairs 0 and 2; if neither matches, pair 1 is
    // the only possible majority.
    always_comb begin
        if (pair_eq[0] || pair_eq[N_CH-1]) begin
            pick_word = ch_words[0];
        end else if (pair_eq[1]) begin
            pick_word = ch_words[1];
        end else begin
            pick_word = safe_word;
        end
    end

endmodule

// File: rtl/tmr_miss_counter.sv
// Saturating count of how often one channel was outvoted.
module tmr_miss_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_word_voter.sv
// Triple-channel whole-word majority voter with safe-value fallback.
module tmr_word_voter
    import tmr_vote_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_vld,
    input  logic [DATA_W-1:0]     ch0_word,
    input  logic [DATA_W-1:0]     ch1_word,
    input  logic [DATA_W-1:0]     ch2_word,
    input  logic [DATA_W-1:0]     safe_word,
    input  logic                  clr_counts,
    output logic [DATA_W-1:0]     vote_word,
    output logic                  vote_valid,
    output logic [2:0]            outvoted,
    output logic                  no_majority,
    output logic [3*CNT_W-1:0]    miss_count
);

    localparam int CNT_BUS_W = N_CH * CNT_W;

    logic [N_CH-1:0][DATA_W-1:0] ch_words;
    logic [DATA_W-1:0]           pick_word;
    logic [N_CH-1:0]             odd_mask;
    logic                        all_agree;
    logic                        none_agree;
    logic [CNT_BUS_W-1:0]        cnt_bus;

    vote_state_e state_q;
    vote_state_e state_d;

    assign ch_words = {ch2_word, ch1_word, ch0_word};

    tmr_word_compare #(
        .DATA_W (DATA_W)
    ) u_compare (
        .ch_words   (ch_words),
        .safe_word  (safe_word),
        .pick_word  (pick_word),
        .odd_mask   (odd_mask),
        .all_agree  (all_agree),
        .none_agree (none_agree)
    );

    // Next outcome state: moves only on a strobe.
    always_comb begin
        state_d = state_q;
        if (sample_vld) begin
            unique case ({all_agree, |odd_mask, none_agree})
                3'b100:  state_d = ST_UNANIMOUS;
                3'b010:  state_d = ST_MASKED;
                3'b001:  state_d = ST_SAFE;
                default: state_d = ST_SAFE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: load on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_word  <= '0;
            vote_valid <= 1'b0;
            outvoted   <= '0;
        end else begin
            vote_valid <= sample_vld;
            if (sample_vld) begin
                vote_word <= pick_word;
                outvoted  <= odd_mask;
            end
        end
    end

    assign no_majority = (state_q == ST_SAFE);

    // One saturating counter per channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_cnt
        tmr_miss_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_counts),
            .bump  (sample_vld & odd_mask[i]),
            .count (cnt_bus[i*CNT_W +: CNT_W])
        );
    end

    assign miss_count = cnt_bus;

endmodule

// File: rtl/tmr_word_voter_chk.sv
// Property checker attached to the voter.
module tmr_word_voter_chk #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_vld,
    input logic [DATA_W-1:0]  ch0_word,
    input logic [DATA_W-1:0]  ch1_word,
    input logic [DATA_W-1:0]  ch2_word,
    input logic [DATA_W-1:0]  safe_word,
    input logic               clr_counts,
    input logic [DATA_W-1:0]  vote_word,
    input logic               vote_valid,
    input logic [2:0]         outvoted,
    input logic               no_majority,
    input logic [3*CNT_W-1:0] miss_count
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic all_diff;
    assign all_diff = (ch0_word != ch1_word) && (ch1_word != ch2_word)
                      && (ch0_word != ch2_word);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> vote_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> !vote_valid);

    // R4
    single_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outvoted));

    // R3
    agree_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && ch0_word == ch1_word) |=> (vote_word == $past(ch0_word)));

    // R5
    safe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && all_diff) |=>
            (no_majority && outvoted == 3'b000 && vote_word == $past(safe_word)));

    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(vote_word) && $stable(outvoted) && $stable(no_majority)));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_counts |=> (miss_count == '0));

    // R10
    nomaj_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && all_diff && !clr_counts) |=> $stable(miss_count));

    for (genvar i = 0; i < 3; i++) begin : g_sat
        // R8
        cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (miss_count[i*CNT_W +: CNT_W] == CNT_TOP && !clr_counts) |=>
                (miss_count[i*CNT_W +: CNT_W] == CNT_TOP));
    end

endmodule

bind tmr_word_voter tmr_word_voter_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .ch0_word    (ch0_word),
    .ch1_word    (ch1_word),
    .ch2_word    (ch2_word),
    .safe_word   (safe_word),
    .clr_counts  (clr_counts),
    .vote_word   (vote_word),
    .vote_valid  (vote_valid),
    .outvoted    (outvoted),
    .no_majority (no_majority),
    .miss_count  (miss_count)
);

// File: tb/tmr_word_voter_bench.sv
`timescale 1ns/1ps
module tmr_word_voter_bench;

    localparam int DW = 8;
    localparam int CW = 3;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_vld = 1'b0;
    logic [DW-1:0]   ch0_word = '0;
    logic [DW-1:0]   ch1_word = '0;
    logic [DW-1:0]   ch2_word = '0;
    logic [DW-1:0]   safe_word = '0;
    logic            clr_counts = 1'b0;
    logic [DW-1:0]   vote_word;
    logic            vote_valid;
    logic [2:0]      outvoted;
    logic            no_majority;
    logic [3*CW-1:0] miss_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [CW-1:0] exp_cnt [3];

    always #4 clk = ~clk;

    tmr_word_voter #(.DATA_W(DW), .CNT_W(CW)) u_tmr_word_voter (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .ch0_word(ch0_word), .ch1_word(ch1_word), .ch2_word(ch2_word),
        .safe_word(safe_word), .clr_counts(clr_counts),
        .vote_word(vote_word), .vote_valid(vote_valid), .outvoted(outvoted),
        .no_majority(no_majority), .miss_count(miss_count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check(req, 64'(miss_count), 64'({exp_cnt[2], exp_cnt[1], exp_cnt[0]}));
    endtask

    // Drive one strobed sample; returns at the next falling edge, after the
    // capturing rising edge.
    task automatic apply(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [DW-1:0] c, input logic [DW-1:0] s,
                         input logic clr_in);
        @(negedge clk);
        ch0_word = a; ch1_word = b; ch2_word = c; safe_word = s;
        sample_vld = 1'b1; clr_counts = clr_in;
        @(negedge clk);
        sample_vld = 1'b0; clr_counts = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 word", 64'(vote_word), 64'h0);
        check("R1 valid", 64'(vote_valid), 64'h0);
        check("R1 flags", 64'({outvoted, no_majority}), 64'h0);
        check_counts("R1 counts");
    endtask

    task automatic t_unanimous();
        apply(8'h5A, 8'h5A, 8'h5A, 8'hFF, 1'b0);
        check("R2 valid pulse", 64'(vote_valid), 64'h1);
        check("R3 word", 64'(vote_word), 64'h5A);
        check("R3 flags", 64'({outvoted, no_majority}), 64'h0);
        check_counts("R10 unanimous counts");
        @(negedge clk);
        check("R2 valid drops", 64'(vote_valid), 64'h0);
    endtask

    task automatic t_single();
        for (int i = 0; i < 3; i++) begin
            logic [DW-1:0] w [3];
            for (int k = 0; k < 3; k++) w[k] = 8'h77;
            w[i] = 8'h33;
            apply(w[0], w[1], w[2], 8'hEE, 1'b0);
            exp_cnt[i] = exp_cnt[i] + 1'b1;
            check("R4 word", 64'(vote_word), 64'h77);
            check("R4 odd flag", 64'(outvoted), 64'(3'b001 << i));
            check("R4 no_majority", 64'(no_majority), 64'h0);
            check_counts("R7 count step");
        end
    endtask

    task automatic t_all_differ();
        apply(8'h01, 8'h02, 8'h03, 8'hC3, 1'b0);
        check("R5 safe word", 64'(vote_word), 64'hC3);
        check("R5 no_majority", 64'(no_majority), 64'h1);
        check("R5 outvoted", 64'(outvoted), 64'h0);
        check_counts("R10 no-majority counts");
    endtask

    task automatic t_hold();
        @(negedge clk);
        ch0_word = 8'h11; ch1_word = 8'h11; ch2_word = 8'h99; safe_word = 8'h00;
        repeat (3) @(negedge clk);
        check("R6 word held", 64'(vote_word), 64'hC3);
        check("R6 flags held", 64'({outvoted, no_majority}), 64'h1);
        check_counts("R6 counts held");
    endtask

    task automatic t_saturate();
        for (int n = 0; n < 10; n++) begin
            apply(8'h40, 8'h41, 8'h40, 8'h00, 1'b0);
            if (exp_cnt[1] != CMAX) exp_cnt[1] = exp_cnt[1] + 1'b1;
        end
        check("R8 saturated field", 64'(miss_count[CW +: CW]), 64'(CMAX));
        check_counts("R8 counts");
    endtask

    task automatic t_clear();
        apply(8'h20, 8'h20, 8'h21, 8'h00, 1'b1);
        for (int k = 0; k < 3; k++) exp_cnt[k] = '0;
        check_counts("R9 clear wins");
        check("R9 vote unaffected", 64'({vote_word, outvoted}), 64'({8'h20, 3'b100}));
        apply(8'h20, 8'h20, 8'h21, 8'h00, 1'b0);
        exp_cnt[2] = 1;
        check_counts("R7 count after clear");
    endtask

    initial begin
        exp_cnt[0] = '0; exp_cnt[1] = '0; exp_cnt[2] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unanimous();
        t_single();
        t_all_differ();
        t_hold();
        t_saturate();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule